// File: doc/BRIEF.md
# Asynchronous EDO DRAM Strobe Cycle Decoder

This block is the device-side control of an asynchronous EDO dynamic memory, rebuilt in a fast synchronous clock domain. It samples the active-low row strobe, column strobe, write enable and output enable pins through a two-stage synchroniser and finds their edges. From the order of those edges it decides which kind of access the host is making. It latches the row and column addresses, writes or reads a small behavioural cell array, and steps an internal refresh row counter. It also decides when the read data may be driven on the data pins.

The decision rests on strobe order alone. A column strobe that is already low when the row strobe falls means a refresh at the counter's row. A row strobe with no column strobe refreshes only the row on the address pins. Write enable low before the column strobe makes an early write. Write enable falling later turns a read into a delayed write or a read-modify-write. A refresh whose row strobe stays low past a threshold enters self refresh, and the counter then steps on an internal timer. Read data follows the extended-data-out rules: it stays on the pins after the column strobe rises, until one of the listed removal conditions occurs.

Top module: `strobe_cycle_ctrl`

## Requirements
- R1: After synchronous reset, `cyc_type` is 0 (idle), `rfsh_cnt` is 0, `dout_en` is 0 and `self_ref` is 0.
- R2: Row strobe falling with the column strobe high, then the column strobe falling with write enable high, gives `cyc_type` 1 (read). The cell at {row low bits, column low bits} appears on `dout`, and `dout_en` is 1 only while `oe_n` is low.
- R3: Write enable low when the column strobe falls, on the first column access of a row, gives `cyc_type` 2 (early write). `din` is stored in the addressed cell and `dout_en` stays 0.
- R4: Write enable falling while both strobes are low after a read gives `cyc_type` 4 (read-modify-write) if the data was driven out with `oe_n` low. Otherwise it gives `cyc_type` 3 (delayed write). In both cases `din` is stored at the latched column and the output turns off.
- R5: Each later column strobe fall within the same row-strobe-low window gives `cyc_type` 5 (page access). It reads, or writes when write enable is low, at the new column.
- R6: Read data stays driven after the column strobe rises while the row strobe is low. It is removed when both strobes are high, or when write enable falls while the column strobe is high.
- R7: Row strobe falling with the column strobe high gives `cyc_type` 6 (row-only refresh) until a column strobe follows. `rfsh_row` takes the row on `addr`, `rfsh_cnt` is unchanged and `dout_en` stays 0.
- R8: Row strobe falling with the column strobe already low and no read data held gives `cyc_type` 7 (strobe-order refresh). `rfsh_row` takes the old `rfsh_cnt`, `rfsh_cnt` steps by one and `dout_en` stays 0.
- R9: Row strobe raised and lowered again while the column strobe stays low after a read gives `cyc_type` 8 (hidden refresh). `rfsh_cnt` steps by one and the read data stays driven.
- R10: A strobe-order refresh whose row strobe stays low for SELF_THRESH cycles gives `cyc_type` 9 and sets `self_ref`. `rfsh_cnt` then steps once every SELF_IVL cycles. Self refresh ends, and the stepping stops, when the row strobe rises.
- R11: `rfsh_cnt` changes only by steps of one and wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row / column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | Data pin drive enable |
| cyc_type | output | 4 | Classified cycle code (see requirements) |
| rfsh_cnt | output | ADDR_W | Internal refresh row counter |
| rfsh_row | output | ADDR_W | Row refreshed most recently |
| self_ref | output | 1 | Self refresh active |

## Verification
The bench builds the block with a 4-bit address, a 3+3-bit cell array and a 40-cycle self-refresh threshold with a 16-cycle step interval. With this configuration every one of the 64 cells can be written and read back in a sweep. Twenty refreshes carry the 4-bit counter through its wrap. Self refresh can be entered and held for several step intervals in a few hundred cycles. Expected cell contents come from an arithmetic pattern kept in a bench-side shadow array.

// File: rtl/strobe_cycle_pkg.sv
package strobe_cycle_pkg;
  typedef enum logic [3:0] {
    CT_IDLE     = 4'd0,
    CT_READ     = 4'd1,
    CT_EARLY_WR = 4'd2,
    CT_DELAY_WR = 4'd3,
    CT_RMW      = 4'd4,
    CT_PAGE     = 4'd5,
    CT_ROW_ONLY = 4'd6,
    CT_CBR      = 4'd7,
    CT_HIDDEN   = 4'd8,
    CT_SELF     = 4'd9
  } cyc_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int            W       = 4,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/self_rfsh_timer.sv
module self_rfsh_timer #(
  parameter int THRESH = 100000,
  parameter int IVL    = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic active,
  output logic tick
);
  localparam int TW = $clog2(THRESH + 1);
  localparam int IW = (IVL > 1) ? $clog2(IVL) : 1;

  logic [TW-1:0] held;
  logic [IW-1:0] ivl;

  always_ff @(posedge clk) begin
    if (rst || !hold) begin
      held   <= '0;
      ivl    <= '0;
      active <= 1'b0;
    end else if (!active) begin
      held <= held + TW'(1);
      if (held == TW'(THRESH - 1)) active <= 1'b1;
    end else begin
      ivl <= (ivl == IW'(IVL - 1)) ? '0 : ivl + IW'(1);
    end
  end

  assign tick = active && hold && (ivl == IW'(IVL - 1));
endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/cycle_decoder.sv
module cycle_decoder
  import strobe_cycle_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 4,
  parameter int ROW_BITS  = 4,
  parameter int COL_BITS  = 4,
  localparam int CELL_W   = ROW_BITS + COL_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n_s,
  input  logic              cas_n_s,
  input  logic              we_n_s,
  input  logic              oe_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  input  logic              self_act,
  input  logic              self_tick,
  output logic              cbr_hold,
  output cyc_e              ctype,
  output logic [ADDR_W-1:0] rfsh_cnt,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              wr_en,
  output logic [CELL_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [CELL_W-1:0] rd_addr,
  output logic              out_on
);
  logic ras_p, cas_p, we_p;
  logic ras_fall, ras_rise, cas_fall, we_fall;
  logic row_open;   // row strobe fell with column strobe high
  logic cas_seen;   // a column access happened in this row window
  logic rd_valid;   // read data is held for the pins
  logic rd_seen;    // held data was driven out with output enable low
  logic cbr_win;    // row strobe low inside a strobe-order refresh
  logic [ROW_BITS-1:0] row_q;
  logic [COL_BITS-1:0] col_q;

  assign ras_fall = ras_p & ~ras_n_s;
  assign ras_rise = ~ras_p & ras_n_s;
  assign cas_fall = cas_p & ~cas_n_s;
  assign we_fall  = we_p & ~we_n_s;

  assign cbr_hold = cbr_win & ~ras_n_s;
  assign out_on   = rd_valid & ~oe_n_s;
  assign rd_addr  = cas_fall ? {row_q, addr_s[COL_BITS-1:0]} : {row_q, col_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p    <= 1'b1;
      cas_p    <= 1'b1;
      we_p     <= 1'b1;
      row_open <= 1'b0;
      cas_seen <= 1'b0;
      rd_valid <= 1'b0;
      rd_seen  <= 1'b0;
      cbr_win  <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      ctype    <= CT_IDLE;
      rfsh_cnt <= '0;
      rfsh_row <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      ras_p <= ras_n_s;
      cas_p <= cas_n_s;
      we_p  <= we_n_s;
      wr_en <= 1'b0;

      if (rd_valid && !oe_n_s) rd_seen <= 1'b1;
      if (ras_n_s && cas_n_s)  rd_valid <= 1'b0;
      if (ras_n_s)             cbr_win <= 1'b0;

      if (ras_rise) begin
        row_open <= 1'b0;
        cas_seen <= 1'b0;
      end

      // R7 / R8 / R9: the column strobe level at the row edge picks the refresh kind
      if (ras_fall) begin
        if (cas_n_s) begin
          ctype    <= CT_ROW_ONLY;
          row_open <= 1'b1;
          cas_seen <= 1'b0;
          rd_valid <= 1'b0;
          row_q    <= addr_s[ROW_BITS-1:0];
          rfsh_row <= addr_s;
        end else begin
          ctype    <= rd_valid ? CT_HIDDEN : CT_CBR;
          cbr_win  <= ~rd_valid;
          rfsh_row <= rfsh_cnt;
          rfsh_cnt <= rfsh_cnt + ADDR_W'(1);
        end
      end

      // R2 / R3 / R5: column access, write enable level decides direction
      if (cas_fall && row_open) begin
        col_q    <= addr_s[COL_BITS-1:0];
        cas_seen <= 1'b1;
        rd_seen  <= 1'b0;
        if (!we_n_s) begin
          ctype    <= cas_seen ? CT_PAGE : CT_EARLY_WR;
          wr_en    <= 1'b1;
          wr_addr  <= {row_q, addr_s[COL_BITS-1:0]};
          wr_data  <= din_s;
          rd_valid <= 1'b0;
        end else begin
          ctype    <= cas_seen ? CT_PAGE : CT_READ;
          rd_valid <= 1'b1;
        end
      end

      // R4 / R6: late write enable edge
      if (we_fall) begin
        if (cas_n_s) begin
          rd_valid <= 1'b0;
        end else if (row_open && cas_seen && !ras_n_s &&
                     (ctype == CT_READ || ctype == CT_PAGE)) begin
          ctype    <= rd_seen ? CT_RMW : CT_DELAY_WR;
          wr_en    <= 1'b1;
          wr_addr  <= {row_q, col_q};
          wr_data  <= din_s;
          rd_valid <= 1'b0;
        end
      end

      // R10: self refresh promotion and timed steps
      if (self_tick) begin
        rfsh_row <= rfsh_cnt;
        rfsh_cnt <= rfsh_cnt + ADDR_W'(1);
      end
      if (self_act && ctype == CT_CBR) ctype <= CT_SELF;
    end
  end
endmodule

// File: rtl/strobe_cycle_ctrl.sv
module strobe_cycle_ctrl
  import strobe_cycle_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 4,
  parameter int ARR_ROW_W   = 4,
  parameter int ARR_COL_W   = 4,
  parameter int SELF_THRESH = 100000,
  parameter int SELF_IVL    = 1562
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [3:0]        cyc_type,
  output logic [ADDR_W-1:0] rfsh_cnt,
  output logic [ADDR_W-1:0] rfsh_row,
  output logic              self_ref
);
  localparam int CELL_W = ARR_ROW_W + ARR_COL_W;
  localparam int SYNC_W = 4 + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {4'b1111, {(ADDR_W + DATA_W){1'b0}}};

  logic [SYNC_W-1:0] sync_q;
  logic              ras_n_s, cas_n_s, we_n_s, oe_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;
  logic              cbr_hold, self_tick, out_on, wr_en;
  logic [CELL_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  cyc_e              ctype;

  // address and data ride the same two stages so they line up with the strobes
  strobe_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ras_n, cas_n, we_n, oe_n, addr, din}),
    .q   (sync_q)
  );
  assign {ras_n_s, cas_n_s, we_n_s, oe_n_s, addr_s, din_s} = sync_q;

  self_rfsh_timer #(.THRESH(SELF_THRESH), .IVL(SELF_IVL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .hold   (cbr_hold),
    .active (self_ref),
    .tick   (self_tick)
  );

  cycle_decoder #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ROW_BITS (ARR_ROW_W),
    .COL_BITS (ARR_COL_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .ras_n_s   (ras_n_s),
    .cas_n_s   (cas_n_s),
    .we_n_s    (we_n_s),
    .oe_n_s    (oe_n_s),
    .addr_s    (addr_s),
    .din_s     (din_s),
    .self_act  (self_ref),
    .self_tick (self_tick),
    .cbr_hold  (cbr_hold),
    .ctype     (ctype),
    .rfsh_cnt  (rfsh_cnt),
    .rfsh_row  (rfsh_row),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .out_on    (out_on)
  );

  cell_array #(.AW(CELL_W), .DW(DATA_W)) u_array (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign cyc_type = ctype;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= out_on ? rd_data : '0;
      dout_en <= out_on;
    end
  end
endmodule

// File: rtl/strobe_cycle_ctrl_chk.sv
module strobe_cycle_ctrl_chk
  import strobe_cycle_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              oe_n,
  input logic              ras_n_s,
  input logic              cas_n_s,
  input logic              wr_en,
  input logic              dout_en,
  input logic              self_ref,
  input logic [3:0]        cyc_type,
  input logic [ADDR_W-1:0] rfsh_cnt
);
  AST_OE_GATES_DOUT: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> ($past(oe_n, 3) == 1'b0)); // R2

  AST_WRITE_IN_CAS: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(cas_n_s)); // R3

  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cyc_type == CT_CBR || cyc_type == CT_SELF) |-> !dout_en); // R8

  AST_SELF_RAS_LOW: assert property (@(posedge clk) disable iff (rst)
    self_ref |-> !$past(ras_n_s)); // R10

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (rfsh_cnt != $past(rfsh_cnt)) |-> (rfsh_cnt == $past(rfsh_cnt) + ADDR_W'(1))); // R11
endmodule

bind strobe_cycle_ctrl strobe_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .oe_n     (oe_n),
  .ras_n_s  (ras_n_s),
  .cas_n_s  (cas_n_s),
  .wr_en    (wr_en),
  .dout_en  (dout_en),
  .self_ref (self_ref),
  .cyc_type (cyc_type),
  .rfsh_cnt (rfsh_cnt)
);

// File: tb/strobe_cycle_ctrl_tb.sv
module strobe_cycle_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 4;
  localparam int THR = 40;
  localparam int IVL = 16;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en, self_ref;
  logic [3:0] cyc_type;
  logic [AW-1:0] rfsh_cnt, rfsh_row;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] shadow [64];
  int exp_cnt = 0;

  always #5 clk = ~clk;

  strobe_cycle_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ARR_ROW_W(3), .ARR_COL_W(3),
    .SELF_THRESH(THR), .SELF_IVL(IVL)
  ) u_dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .cyc_type(cyc_type),
    .rfsh_cnt(rfsh_cnt), .rfsh_row(rfsh_row), .self_ref(self_ref)
  );

  function automatic logic [DW-1:0] pat(int r, int c);
    return DW'((r * 8 + c) * 7 + 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drv(input logic r, input logic c, input logic w, input logic o);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_cyc(2);
    chk("R1 type", cyc_type, 0);
    chk("R1 cnt", rfsh_cnt, 0);
    chk("R1 dout_en", dout_en, 0);
    chk("R1 self", self_ref, 0);

    // R3: early write sweep over every cell
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        addr = AW'(r); drv(0, 1, 1, 1);
        din = pat(r, c); drv(0, 1, 0, 1);
        addr = AW'(c); drv(0, 0, 0, 1);
        chk("R3 type", cyc_type, 2);
        chk("R3 dout_en", dout_en, 0);
        shadow[r * 8 + c] = pat(r, c);
        drv(0, 1, 0, 1);
        drv(1, 1, 1, 1);
      end
    end

    // R2: read sweep, and R6 removal by both strobes high
    for (int r = 0; r < 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        addr = AW'(r); drv(0, 1, 1, 1);
        addr = AW'(c); drv(0, 0, 1, 0);
        chk("R2 type", cyc_type, 1);
        chk("R2 dout_en", dout_en, 1);
        chk("R2 data", dout, shadow[r * 8 + c]);
        drv(1, 1, 1, 0);
        chk("R6 both high off", dout_en, 0);
        drv(1, 1, 1, 1);
      end
    end

    // R2: output enable gating, R6 hold after column strobe rises
    addr = 4'd3; drv(0, 1, 1, 1);
    addr = 4'd5; drv(0, 0, 1, 1);
    chk("R2 oe high off", dout_en, 0);
    drv(0, 0, 1, 0);
    chk("R2 oe low on", dout_en, 1);
    chk("R2 oe low data", dout, shadow[3 * 8 + 5]);
    drv(0, 1, 1, 0);
    chk("R6 edo hold en", dout_en, 1);
    chk("R6 edo hold data", dout, shadow[3 * 8 + 5]);
    drv(0, 1, 1, 1);
    chk("R2 oe high again", dout_en, 0);
    drv(0, 1, 1, 0);
    chk("R6 oe low again", dout_en, 1);
    drv(1, 1, 1, 1);

    // R5: page access with read, WE pulse removal, then page write
    addr = 4'd2; drv(0, 1, 1, 1);
    addr = 4'd0; drv(0, 0, 1, 0);
    chk("R2 page first", cyc_type, 1);
    drv(0, 1, 1, 0);
    addr = 4'd1; drv(0, 0, 1, 0);
    chk("R5 page type", cyc_type, 5);
    chk("R5 page data", dout, shadow[2 * 8 + 1]);
    drv(0, 1, 1, 0);
    chk("R6 page hold", dout_en, 1);
    drv(0, 1, 0, 0);
    chk("R6 we pulse off", dout_en, 0);
    din = 4'hA; addr = 4'd3; drv(0, 0, 0, 0);
    chk("R5 page write type", cyc_type, 5);
    chk("R5 page write quiet", dout_en, 0);
    shadow[2 * 8 + 3] = 4'hA;
    drv(0, 1, 0, 1);
    drv(1, 1, 1, 1);
    addr = 4'd2; drv(0, 1, 1, 1);
    addr = 4'd3; drv(0, 0, 1, 0);
    chk("R5 page write readback", dout, 10);
    drv(1, 1, 1, 1);

    // R4: delayed write (output never enabled)
    addr = 4'd1; drv(0, 1, 1, 1);
    addr = 4'd2; drv(0, 0, 1, 1);
    din = 4'h9; drv(0, 0, 0, 1);
    chk("R4 delayed type", cyc_type, 3);
    shadow[1 * 8 + 2] = 4'h9;
    drv(0, 1, 0, 1);
    drv(1, 1, 1, 1);
    addr = 4'd1; drv(0, 1, 1, 1);
    addr = 4'd2; drv(0, 0, 1, 0);
    chk("R4 delayed readback", dout, 9);
    drv(1, 1, 1, 1);

    // R4: read-modify-write
    addr = 4'd4; drv(0, 1, 1, 1);
    addr = 4'd4; drv(0, 0, 1, 0);
    chk("R4 rmw read", dout, shadow[4 * 8 + 4]);
    din = 4'h5; drv(0, 0, 0, 0);
    chk("R4 rmw type", cyc_type, 4);
    chk("R4 rmw out off", dout_en, 0);
    shadow[4 * 8 + 4] = 4'h5;
    drv(0, 1, 0, 1);
    drv(1, 1, 1, 1);
    addr = 4'd4; drv(0, 1, 1, 1);
    addr = 4'd4; drv(0, 0, 1, 0);
    chk("R4 rmw readback", dout, 5);
    drv(1, 1, 1, 1);

    // R7: row-only refresh
    addr = 4'd13; drv(0, 1, 1, 0);
    chk("R7 type", cyc_type, 6);
    chk("R7 row", rfsh_row, 13);
    chk("R7 cnt kept", rfsh_cnt, exp_cnt);
    chk("R7 quiet", dout_en, 0);
    drv(1, 1, 1, 1);

    // R8 / R11: strobe-order refresh across the counter wrap
    for (int k = 0; k < 20; k++) begin
      drv(1, 0, 1, 0);
      drv(0, 0, 1, 0);
      chk("R8 type", cyc_type, 7);
      chk("R8 row", rfsh_row, exp_cnt);
      exp_cnt = (exp_cnt + 1) % 16;
      chk("R11 cnt", rfsh_cnt, exp_cnt);
      chk("R8 quiet", dout_en, 0);
      drv(1, 0, 1, 1);
      drv(1, 1, 1, 1);
    end

    // R9: hidden refresh keeps read data
    addr = 4'd6; drv(0, 1, 1, 1);
    addr = 4'd6; drv(0, 0, 1, 0);
    drv(1, 0, 1, 0);
    chk("R9 data across ras high", dout_en, 1);
    drv(0, 0, 1, 0);
    chk("R9 type", cyc_type, 8);
    chk("R9 row", rfsh_row, exp_cnt);
    exp_cnt = (exp_cnt + 1) % 16;
    chk("R9 cnt", rfsh_cnt, exp_cnt);
    chk("R9 dout_en", dout_en, 1);
    chk("R9 data", dout, shadow[6 * 8 + 6]);
    drv(1, 0, 1, 0);
    drv(1, 1, 1, 0);
    chk("R6 after hidden off", dout_en, 0);
    drv(1, 1, 1, 1);

    // R10: short refresh stays below the threshold
    drv(1, 0, 1, 1);
    @(negedge clk); ras_n = 1'b0;
    wait_cyc(30);
    chk("R10 short type", cyc_type, 7);
    chk("R10 short self", self_ref, 0);
    exp_cnt = (exp_cnt + 1) % 16;
    chk("R10 short cnt", rfsh_cnt, exp_cnt);
    drv(1, 0, 1, 1);
    drv(1, 1, 1, 1);

    // R10: long refresh enters self refresh and steps on the timer
    drv(1, 0, 1, 1);
    @(negedge clk); ras_n = 1'b0;
    wait_cyc(8);
    chk("R10 before thresh", cyc_type, 7);
    chk("R10 before self", self_ref, 0);
    wait_cyc(THR + 3 * IVL + IVL / 2 - 8);
    chk("R10 self type", cyc_type, 9);
    chk("R10 self flag", self_ref, 1);
    exp_cnt = (exp_cnt + 4) % 16;
    chk("R10 self steps", rfsh_cnt, exp_cnt);
    drv(1, 0, 1, 1);
    chk("R10 exit flag", self_ref, 0);
    wait_cyc(3 * IVL);
    chk("R10 no steps after exit", rfsh_cnt, exp_cnt);
    drv(1, 1, 1, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule